// File: doc/BRIEF.md
# Serial Word-Addressed Memory Slave with Self-Timed Programming

This block models a small non-volatile memory of 16 words of 16 bits. An external master reaches it over four serial wires: a select line, a serial clock, a data input and a data output. Every pin is brought into the system clock domain through a synchronizer, and the block acts only on serial clock rising edges it detects there. A frame is a start bit of one, a 2-bit opcode and a 6-bit address field. Write-type frames then add a 16-bit data field.

The block supports seven instructions: read, write, erase, enable, disable, erase-all and write-all. Reads return a dummy zero followed by the word, most significant bit first. Write-type instructions are only queued while the frame is shifted in. They take effect when the select line falls, and that starts a self-timed busy period. If the master raises select during that period, the data output reports the progress of the programming cycle. Write-type instructions are locked out until an enable instruction has been received.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset, `dout_oe_o` is 0, write-type instructions are locked, and every word reads 16'hFFFF.
- R2: While `cs_i` is low, `dout_oe_o` stays 0. Serial clock and data toggling has no effect on the stored words.
- R3: Any number of 0 bits received before the first 1 with `cs_i` high are discarded. That first 1 is the start bit.
- R4: Read uses opcode 2'b10. Address bits [3:0] pick the word and bits [5:4] are ignored. On the rising serial clock that carries the last address bit, the output turns on driving 0. Each of the next 16 rising edges drives one data bit, bit 15 first. The rising edge after those 16 releases the output.
- R5: Write uses opcode 2'b01, followed by 16 data bits sent bit 15 first. The word is replaced when `cs_i` falls, whatever its earlier content, with no erase needed first.
- R6: Erase uses opcode 2'b11. When `cs_i` falls, the addressed word is set to 16'hFFFF.
- R7: Opcode 2'b00 takes its instruction from address bits [5:4]. 2'b11 enables write-type instructions and 2'b00 disables them. While disabled, write, erase, write-all and erase-all leave the memory unchanged.
- R8: Opcode 2'b00 with address bits [5:4] = 2'b01 is write-all: it takes 16 data bits and writes them into every word. With 2'b10 it is erase-all, which sets every word to 16'hFFFF.
- R9: Programming lasts PROG_CYCLES system clocks from the fall of `cs_i`. If `cs_i` is raised meanwhile, the output is driven 0 while busy and 1 once ready. Frames clocked in while busy are ignored.
- R10: A write whose select falls before all 16 data bits have arrived changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Select, active high |
| sclk_i | input | 1 | Serial clock from the master |
| din_i | input | 1 | Serial data from the master |
| dout_o | output | 1 | Serial data or status to the master |
| dout_oe_o | output | 1 | High when `dout_o` is driven; low means high impedance |

## Verification
The bench goes after several corner cases:
- Reads with leading zeros and with every setting of the two ignored address bits. A design that mis-framed these would return shifted words, or the wrong word.
- A write frame cut short by an early fall of select. A design that committed on select fall without counting the data bits would corrupt that word.
- A disable frame clocked in while programming is busy, followed by a write that must still succeed. A design that decoded frames during busy would lock itself out.
- Write-type instructions sent before enable and after disable, which must leave the memory unchanged.
- The status bit, sampled both near the end of the busy window and just after it, which catches a programming cycle of the wrong length.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    // opcode field values
    typedef enum logic [1:0] {
        OPC_EXT   = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_ERASE = 2'b11
    } opc_e;

    typedef enum logic [2:0] {
        INS_READ,
        INS_WRITE,
        INS_ERASE,
        INS_ENABLE,
        INS_DISABLE,
        INS_ERASE_ALL,
        INS_WRITE_ALL
    } ins_e;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_OPC,
        ST_ADR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } fst_e;

    typedef enum logic [1:0] {
        PG_WORD,
        PG_ERASE,
        PG_FILL,
        PG_CLEAR
    } pgm_e;

    // synchronized pin levels and detected edges
    typedef struct packed {
        logic sel;
        logic sel_rise;
        logic sel_fall;
        logic sck_rise;
        logic din;
    } pin_evt_t;

    function automatic ins_e decode_ins(input logic [1:0] opc, input logic [1:0] ext);
        case (opc)
            OPC_READ:  return INS_READ;
            OPC_WRITE: return INS_WRITE;
            OPC_ERASE: return INS_ERASE;
            default: begin
                case (ext)
                    2'b11:   return INS_ENABLE;
                    2'b00:   return INS_DISABLE;
                    2'b10:   return INS_ERASE_ALL;
                    default: return INS_WRITE_ALL;
                endcase
            end
        endcase
    endfunction

    function automatic pgm_e to_pgm(input ins_e ins);
        case (ins)
            INS_WRITE:     return PG_WORD;
            INS_ERASE:     return PG_ERASE;
            INS_WRITE_ALL: return PG_FILL;
            default:       return PG_CLEAR;
        endcase
    endfunction

endpackage

// File: rtl/uwire_sync.sv
module uwire_sync
    import uwire_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_i,
    input  logic     sclk_i,
    input  logic     din_i,
    output pin_evt_t evt
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] cs_sh, sk_sh, di_sh;
    logic              cs_d, sk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_sh <= '0;
            sk_sh <= '0;
            di_sh <= '0;
            cs_d  <= 1'b0;
            sk_d  <= 1'b0;
        end else begin
            cs_sh[0] <= cs_i;
            sk_sh[0] <= sclk_i;
            di_sh[0] <= din_i;
            for (int k = 1; k < STAGES; k++) begin
                cs_sh[k] <= cs_sh[k-1];
                sk_sh[k] <= sk_sh[k-1];
                di_sh[k] <= di_sh[k-1];
            end
            cs_d <= cs_sh[TOP];
            sk_d <= sk_sh[TOP];
        end
    end

    always_comb begin
        evt.sel      = cs_sh[TOP];
        evt.sel_rise = cs_sh[TOP] & ~cs_d;
        evt.sel_fall = ~cs_sh[TOP] & cs_d;
        evt.sck_rise = sk_sh[TOP] & ~sk_d & cs_sh[TOP];
        evt.din      = di_sh[TOP];
    end

endmodule

// File: rtl/uwire_store.sv
module uwire_store
    import uwire_pkg::*;
#(
    parameter int WORDS       = 16,
    parameter int WIDTH       = 16,
    parameter int PROG_CYCLES = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  pgm_e                     kind,
    input  logic [$clog2(WORDS)-1:0] addr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(WORDS)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata,
    output logic                     busy
);
    localparam int IW = $clog2(WORDS);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [WORDS-1:0][WIDTH-1:0] words;
    logic [CW-1:0]               timer;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WIDTH-1:0] q;
        logic             hit;
        assign hit = start && ((kind == PG_FILL) || (kind == PG_CLEAR) || (addr == IW'(w)));
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '1;
            end else if (hit) begin
                q <= ((kind == PG_WORD) || (kind == PG_FILL)) ? wdata : '1;
            end
        end
        assign words[w] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            timer <= '0;
        end else if (start) begin
            timer <= CW'(PROG_CYCLES);
        end else if (timer != '0) begin
            timer <= timer - CW'(1);
        end
    end

    assign busy  = (timer != '0);
    assign rdata = words[raddr];

    // R9: a new programming cycle never begins on top of a running one
    p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R9: busy is reported from the cycle after programming begins
    p_busy_follows_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R9: the programming timer stays within its configured length
    p_timer_bound_r9: assert property (@(posedge clk) disable iff (rst)
        timer <= CW'(PROG_CYCLES));

    // R2: stored words only change as the result of a programming start
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(start) |-> $stable(words));

endmodule

// File: rtl/uwire_cmd.sv
module uwire_cmd
    import uwire_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int IW       = 4,
    parameter int ADR_BITS = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  pin_evt_t       evt,
    input  logic           busy,
    input  logic [WIDTH-1:0] rdata,
    output logic [IW-1:0]  raddr,
    output logic           prog_start,
    output pgm_e           prog_kind,
    output logic [IW-1:0]  prog_addr,
    output logic [WIDTH-1:0] prog_data,
    output logic           dout,
    output logic           dout_oe
);
    localparam int LONGEST = (WIDTH > ADR_BITS) ? WIDTH : ADR_BITS;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    fst_e                state;
    logic [CNT_W-1:0]    cnt;
    logic [1:0]          opc_q;
    logic [ADR_BITS-2:0] adr_q;
    logic [IW-1:0]       idx_q;
    logic [WIDTH-1:0]    dat_q;
    logic [WIDTH-1:0]    sreg;
    ins_e                ins_q;
    logic                pend_q, en_q, rd_oe_q, rd_bit_q, stat_q;

    logic [ADR_BITS-1:0] full_adr;
    ins_e                ins_now;

    assign full_adr = {adr_q, evt.din};
    assign ins_now  = decode_ins(opc_q, full_adr[ADR_BITS-1 -: 2]);
    assign raddr    = full_adr[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            cnt      <= '0;
            opc_q    <= '0;
            adr_q    <= '0;
            idx_q    <= '0;
            dat_q    <= '0;
            sreg     <= '0;
            ins_q    <= INS_READ;
            pend_q   <= 1'b0;
            en_q     <= 1'b0;
            rd_oe_q  <= 1'b0;
            rd_bit_q <= 1'b0;
            stat_q   <= 1'b0;
        end else if (evt.sel_rise) begin
            state   <= ST_HUNT;
            cnt     <= '0;
            pend_q  <= 1'b0;
            rd_oe_q <= 1'b0;
            stat_q  <= busy;
        end else if (evt.sel_fall) begin
            state   <= ST_HUNT;
            pend_q  <= 1'b0;
            rd_oe_q <= 1'b0;
            stat_q  <= 1'b0;
        end else if (evt.sck_rise && !busy) begin
            case (state)
                ST_HUNT: begin
                    if (evt.din) begin
                        state  <= ST_OPC;
                        cnt    <= '0;
                        stat_q <= 1'b0;
                    end
                end
                ST_OPC: begin
                    opc_q <= {opc_q[0], evt.din};
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_ADR;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_ADR: begin
                    adr_q <= full_adr[ADR_BITS-2:0];
                    if (cnt == CNT_W'(ADR_BITS - 1)) begin
                        cnt   <= '0;
                        ins_q <= ins_now;
                        idx_q <= full_adr[IW-1:0];
                        case (ins_now)
                            INS_READ: begin
                                sreg     <= rdata;
                                rd_oe_q  <= 1'b1;
                                rd_bit_q <= 1'b0;
                                state    <= ST_READ;
                            end
                            INS_WRITE, INS_WRITE_ALL: state <= ST_DATA;
                            INS_ENABLE: begin
                                en_q  <= 1'b1;
                                state <= ST_DONE;
                            end
                            INS_DISABLE: begin
                                en_q  <= 1'b0;
                                state <= ST_DONE;
                            end
                            default: begin
                                pend_q <= 1'b1;
                                state  <= ST_DONE;
                            end
                        endcase
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    dat_q <= {dat_q[WIDTH-2:0], evt.din};
                    if (cnt == CNT_W'(WIDTH - 1)) begin
                        pend_q <= 1'b1;
                        state  <= ST_DONE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_READ: begin
                    if (cnt == CNT_W'(WIDTH)) begin
                        rd_oe_q <= 1'b0;
                        state   <= ST_DONE;
                    end else begin
                        rd_bit_q <= sreg[WIDTH-1];
                        sreg     <= {sreg[WIDTH-2:0], 1'b0};
                        cnt      <= cnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign prog_start = evt.sel_fall && pend_q && en_q && !busy;
    assign prog_kind  = to_pgm(ins_q);
    assign prog_addr  = idx_q;
    assign prog_data  = dat_q;
    assign dout_oe    = evt.sel & (rd_oe_q | stat_q);
    assign dout       = rd_oe_q ? rd_bit_q : (stat_q & ~busy);

    // R2: nothing is driven once select has been low for a cycle
    p_quiet_deselected_r2: assert property (@(posedge clk) disable iff (rst)
        (!evt.sel && $past(!evt.sel)) |-> !dout_oe);

    // R9: read data and status never own the output together
    p_one_source_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_oe_q, stat_q}));

    // R9: status reads low while programming is running
    p_status_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (stat_q && busy) |-> !dout);

    // R4: the first bit of a read is the dummy zero
    p_dummy_first_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_oe_q) |-> !rd_bit_q);

endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
    import uwire_pkg::*;
#(
    parameter int WORDS       = 16,
    parameter int WIDTH       = 16,
    parameter int ADR_BITS    = 6,
    parameter int PROG_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic din_i,
    output logic dout_o,
    output logic dout_oe_o
);
    localparam int IW = $clog2(WORDS);

    pin_evt_t         evt;
    logic             busy;
    logic             prog_start;
    pgm_e             prog_kind;
    logic [IW-1:0]    prog_addr;
    logic [IW-1:0]    raddr;
    logic [WIDTH-1:0] prog_data;
    logic [WIDTH-1:0] rdata;

    uwire_sync #(
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst   (rst),
        .cs_i  (cs_i),
        .sclk_i(sclk_i),
        .din_i (din_i),
        .evt   (evt)
    );

    uwire_cmd #(
        .WIDTH   (WIDTH),
        .IW      (IW),
        .ADR_BITS(ADR_BITS)
    ) i_cmd (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .busy      (busy),
        .rdata     (rdata),
        .raddr     (raddr),
        .prog_start(prog_start),
        .prog_kind (prog_kind),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .dout      (dout_o),
        .dout_oe   (dout_oe_o)
    );

    uwire_store #(
        .WORDS      (WORDS),
        .WIDTH      (WIDTH),
        .PROG_CYCLES(PROG_CYCLES)
    ) i_store (
        .clk  (clk),
        .rst  (rst),
        .start(prog_start),
        .kind (prog_kind),
        .addr (prog_addr),
        .wdata(prog_data),
        .raddr(raddr),
        .rdata(rdata),
        .busy (busy)
    );

endmodule

// File: tb/test_uwire_eeprom.sv
module test_uwire_eeprom;

    localparam int PROG = 400;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, sclk = 1'b0, din = 1'b0;
    logic dout, dout_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic q_s, oe_s;
    logic [15:0] mdl [16];

    always #2 clk = ~clk;

    uwire_eeprom #(.PROG_CYCLES(PROG)) i_uwire_eeprom (
        .clk      (clk),
        .rst      (rst),
        .cs_i     (cs),
        .sclk_i   (sclk),
        .din_i    (din),
        .dout_o   (dout),
        .dout_oe_o(dout_oe)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b);
        din = b;
        wait_clks(HALF);
        sclk = 1'b1;
        wait_clks(HALF);
        q_s  = dout;
        oe_s = dout_oe;
        sclk = 1'b0;
    endtask

    task automatic sel_on();
        cs = 1'b1;
        wait_clks(HALF);
    endtask

    task automatic sel_off();
        cs  = 1'b0;
        din = 1'b0;
        wait_clks(HALF);
    endtask

    task automatic head(input logic [1:0] op, input logic [5:0] a, input int zeros);
        sel_on();
        repeat (zeros) sbit(1'b0);
        sbit(1'b1);
        sbit(op[1]);
        sbit(op[0]);
        for (int k = 5; k >= 0; k--) sbit(a[k]);
    endtask

    task automatic read_chk(input logic [3:0] idx, input logic [1:0] top, input int zeros,
                            input logic [15:0] exp, input string tag);
        logic [15:0] got;
        bit          all_on;
        got    = '0;
        all_on = 1'b1;
        head(2'b10, {top, idx}, zeros);
        check(oe_s === 1'b1 && q_s === 1'b0, "R4 dummy bit", {30'd0, oe_s, q_s}, 32'h2);
        for (int k = 0; k < 16; k++) begin
            sbit(1'b0);
            got = {got[14:0], q_s};
            if (oe_s !== 1'b1) all_on = 1'b0;
        end
        check(all_on, "R4 output held on", {31'd0, all_on}, 32'h1);
        sbit(1'b0);
        check(oe_s === 1'b0, "R4 release after last bit", {31'd0, oe_s}, 32'h0);
        sel_off();
        check(got === exp, tag, {16'd0, got}, {16'd0, exp});
    endtask

    task automatic wr_frame(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d, input int nbits);
        head(op, a, 0);
        for (int k = 0; k < nbits; k++) sbit(d[15-k]);
        sel_off();
        wait_clks(PROG + 20);
    endtask

    task automatic ext(input logic [1:0] top);
        head(2'b00, {top, 4'h0}, 0);
        sel_off();
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 16; i++) read_chk(4'(i), 2'(i) ^ 2'b10, 0, mdl[i], tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = 16'hFFFF;
        wait_clks(5);
        rst = 1'b0;
        wait_clks(3);

        // R1: output released, memory erased
        check(dout_oe === 1'b0, "R1 output off after reset", {31'd0, dout_oe}, 32'h0);
        sweep("R1 erased after reset");

        // R7: locked at power up
        wr_frame(2'b01, 6'h03, 16'h1234, 16);
        read_chk(4'h3, 2'b00, 0, 16'hFFFF, "R7 write while locked");

        ext(2'b11);
        // R5 and R4: write each word, read with all top-bit settings
        for (int i = 0; i < 16; i++) begin
            logic [15:0] d;
            d = 16'h5A3C ^ (16'(i) * 16'h1111) ^ (16'(i) << 9);
            wr_frame(2'b01, {2'(~i), 4'(i)}, d, 16);
            mdl[i] = d;
        end
        sweep("R5 written words");

        // R5: overwrite without prior erase
        mdl[4] = ~mdl[4];
        wr_frame(2'b01, 6'h04, mdl[4], 16);
        read_chk(4'h4, 2'b11, 0, mdl[4], "R5 overwrite");

        // R3: leading zeros before start bit
        read_chk(4'h6, 2'b01, 7, mdl[6], "R3 leading zeros");

        // R6: single word erase
        wr_frame(2'b11, 6'h25, 16'h0000, 0);
        mdl[5] = 16'hFFFF;
        read_chk(4'h5, 2'b00, 0, mdl[5], "R6 erase word");

        // R9: status, busy length and frames ignored while busy
        head(2'b01, 6'h02, 0);
        for (int k = 0; k < 16; k++) sbit(k[0]);
        sel_off();
        mdl[2] = 16'h5555;
        sel_on();
        wait_clks(3);
        check(dout_oe === 1'b1 && dout === 1'b0, "R9 status busy", {30'd0, dout_oe, dout}, 32'h2);
        sbit(1'b1);
        for (int k = 0; k < 8; k++) sbit(1'b0);
        wait_clks(PROG - 180);
        check(dout_oe === 1'b1 && dout === 1'b0, "R9 still busy near end", {30'd0, dout_oe, dout}, 32'h2);
        wait_clks(100);
        check(dout_oe === 1'b1 && dout === 1'b1, "R9 status ready", {30'd0, dout_oe, dout}, 32'h3);
        sel_off();
        mdl[8] = 16'hBEEF;
        wr_frame(2'b01, 6'h08, 16'hBEEF, 16);
        read_chk(4'h8, 2'b10, 0, mdl[8], "R9 disable ignored while busy");
        read_chk(4'h2, 2'b01, 0, mdl[2], "R9 programmed word");

        // R10: truncated write frame
        wr_frame(2'b01, 6'h09, 16'h0000, 8);
        read_chk(4'h9, 2'b00, 0, mdl[9], "R10 truncated write");

        // R2: traffic while deselected
        begin
            bit quiet;
            quiet = 1'b1;
            sbit(1'b1); sbit(1'b0); sbit(1'b1);
            for (int k = 0; k < 6; k++) sbit(k == 5);
            for (int k = 0; k < 16; k++) begin
                sbit(1'b0);
                if (oe_s !== 1'b0) quiet = 1'b0;
            end
            check(quiet, "R2 output off while deselected", {31'd0, quiet}, 32'h1);
            wait_clks(PROG + 20);
            read_chk(4'h1, 2'b00, 0, mdl[1], "R2 no write while deselected");
        end

        // R8: write-all and erase-all
        wr_frame(2'b00, 6'h10, 16'hC3A5, 16);
        for (int i = 0; i < 16; i++) mdl[i] = 16'hC3A5;
        sweep("R8 write-all");
        wr_frame(2'b00, 6'h20, 16'h0000, 0);
        for (int i = 0; i < 16; i++) mdl[i] = 16'hFFFF;
        sweep("R8 erase-all");

        // R7: disable locks write-type instructions again
        ext(2'b00);
        wr_frame(2'b01, 6'h00, 16'h1234, 16);
        read_chk(4'h0, 2'b00, 0, 16'hFFFF, "R7 write after disable");
        wr_frame(2'b00, 6'h10, 16'h0000, 16);
        read_chk(4'hF, 2'b11, 0, 16'hFFFF, "R7 write-all after disable");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule